// File: doc/BRIEF.md
# Local Timebase Rate Scaler

This block produces the advance strobe for a 64-bit timebase that sits next to a group of processor cores, and keeps that timebase. One of two tick strobes drives it: a crystal reference tick or an alternative tick derived from the bus clock. The block scales the chosen strobe by a fractional factor. With rate value P, the output rate is the input rate times P / 2^31, so 0x80000000 passes every input tick through. Each produced tick advances the count by one, or by two when the double-step option is set.

Two write-only registers control it. Select 0 is the mode register: bit 8 chooses the alternative source and bit 9 chooses the double step. Select 1 is the 32-bit rate register. Both registers clear on reset, so the timebase holds at zero until software writes a non-zero rate. Compare logic and interrupt generation belong to the cores and are not in this block.

Top module: `ltmr_prescale_top`

## Requirements
- R1: After reset, `count_o` is 0, `cnt_tick_o` is 0, and reference ticks leave the count at 0 until the rate register is written.
- R2: Mode bit 8 = 0 makes the reference tick drive the scaler and ignores the alternative tick. Bit 8 = 1 does the reverse.
- R3: Mode bit 9 = 0 advances the count by 1 per produced tick. Bit 9 = 1 advances it by 2.
- R4: With rate 0x80000000, every selected input tick produces one output tick.
- R5: With rate P ≤ 0x80000000, a 31-bit residue r is kept between ticks. Each selected tick forms r + P. It produces a tick when that sum is at least 2^31 and then keeps the sum minus 2^31. Over N ticks, floor((r + N·P) / 2^31) ticks result.
- R6: Rate 0 never produces an output tick, so the count holds.
- R7: A rate above 0x80000000 acts as 0x80000000, which gives one output tick per selected input tick.
- R8: The count wraps to zero after all ones (checked on a narrowed count width).
- R9: A register write takes effect the cycle after it. A selected tick in the same cycle as the write uses the old source, rate and step.
- R10: `cnt_tick_o` is high in exactly the cycles whose closing edge advances the count. It is combinational from the selected tick and the current residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Crystal reference tick strobe |
| alt_tick_i | input | 1 | Bus-derived tick strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = mode register, 1 = rate register |
| reg_wdata_i | input | 32 | Write data |
| cnt_tick_o | output | 1 | Advance strobe for the current cycle |
| count_o | output | CNT_W (64) | Timebase count |

## Verification
A register write and a selected input tick can land in the same cycle. This matters because the tick then depends on whether the old or the new rate, source or step is used. The bench raises the tick in the same cycle as a rate change (to 0 and back to unity), a step change, and a source change. It then expects the old setting on that edge and the new setting on the next one. A shadow model is updated only after the edge, and each cycle's strobe and count are compared against it.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
  localparam int unsigned RATE_W   = 32;
  localparam int unsigned SRC_BIT  = 8;
  localparam int unsigned STEP_BIT = 9;
  localparam logic [RATE_W-1:0] UNITY = {1'b1, {(RATE_W-1){1'b0}}};

  typedef struct packed {
    logic step2;
    logic alt_src;
  } ltp_mode_t;

  // Rates above unity are treated as unity.
  function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] p);
    return (p > UNITY) ? UNITY : p;
  endfunction

  // Widened sum of residue and rate; never overflows RATE_W+1 bits.
  function automatic logic [RATE_W:0] acc_sum(input logic [RATE_W-1:0] a,
                                               input logic [RATE_W-1:0] p);
    return {1'b0, a} + {1'b0, p};
  endfunction
endpackage

// File: rtl/ltp_regs.sv
module ltp_regs
  import ltp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [RATE_W-1:0] wdata_i,
  output ltp_mode_t         mode_o,
  output logic [RATE_W-1:0] rate_o
);
  ltp_mode_t         mode_q;
  logic [RATE_W-1:0] rate_q;
  logic              mode_we, rate_we;

  assign mode_we = wr_i & ~sel_i;
  assign rate_we = wr_i &  sel_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= '0;
    end else begin
      if (mode_we) begin
        mode_q.alt_src <= wdata_i[SRC_BIT];
        mode_q.step2   <= wdata_i[STEP_BIT];
      end
      if (rate_we) rate_q <= wdata_i;
    end
  end

  assign mode_o = mode_q;
  assign rate_o = rate_q;

  // R9: without a write strobe the settings hold
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(rate_q) && $stable(mode_q)));
  // R9: a rate write is visible on the following cycle
  assert_rate_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_we |=> (rate_q == $past(wdata_i)));
endmodule

// File: rtl/ltp_src_mux.sv
module ltp_src_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick_i,
  input  logic alt_tick_i,
  input  logic alt_sel_i,
  output logic tick_o
);
  assign tick_o = alt_sel_i ? alt_tick_i : ref_tick_i;

  // R2: the unselected strobe alone never produces a tick
  assert_ignore_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_sel_i && !ref_tick_i) |-> !tick_o);
  assert_ignore_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel_i && !alt_tick_i) |-> !tick_o);
endmodule

// File: rtl/ltp_frac_acc.sv
module ltp_frac_acc
  import ltp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              out_tick_o
);
  logic [RATE_W-1:0] acc_q, acc_d, rate_eff;
  logic [RATE_W:0]   sum, diff;
  logic              carry;

  assign rate_eff = clamp_rate(rate_i);
  assign sum      = acc_sum(acc_q, rate_eff);
  assign carry    = (sum >= {1'b0, UNITY});
  assign diff     = sum - {1'b0, UNITY};

  always_comb begin
    acc_d = acc_q;
    if (in_tick_i) acc_d = carry ? diff[RATE_W-1:0] : sum[RATE_W-1:0];
  end

  assign out_tick_o = in_tick_i & carry;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R5: residue stays below one whole tick
  assert_residue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < UNITY);
  // R6: a zero rate never produces a tick
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |-> !out_tick_o);
  // R4 / R7: unity or larger passes every input tick
  assert_unity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tick_i && rate_i >= UNITY) |-> out_tick_o);
  // R5: idle input keeps the residue
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tick_i |=> $stable(acc_q));
endmodule

// File: rtl/ltp_counter.sv
module ltp_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             step2_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] STEP_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_TWO = CNT_W'(2);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (adv_i) count_q <= count_q + (step2_i ? STEP_TWO : STEP_ONE);
  end

  assign count_o = count_q;

  // R10: no advance strobe, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(count_q));
  // R3: single step moves by one (modulo width, R8)
  assert_step1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !step2_i) |=> (count_q - $past(count_q) == STEP_ONE));
  assert_step2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && step2_i) |=> (count_q - $past(count_q) == STEP_TWO));
endmodule

// File: rtl/ltmr_prescale_top.sv
module ltmr_prescale_top
  import ltp_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick_i,
  input  logic             alt_tick_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  output logic             cnt_tick_o,
  output logic [CNT_W-1:0] count_o
);
  ltp_mode_t         mode;
  logic [RATE_W-1:0] rate;
  logic              sel_tick;
  logic              adv;

  ltp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .mode_o(mode), .rate_o(rate)
  );

  ltp_src_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .alt_tick_i(alt_tick_i),
    .alt_sel_i(mode.alt_src), .tick_o(sel_tick)
  );

  ltp_frac_acc u_acc (
    .clk(clk), .rst_n(rst_n), .in_tick_i(sel_tick), .rate_i(rate),
    .out_tick_o(adv)
  );

  ltp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .step2_i(mode.step2),
    .count_o(count_o)
  );

  assign cnt_tick_o = adv;

  // R10: an output tick needs a selected input tick
  assert_tick_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick_o |-> sel_tick);
endmodule

// File: tb/ltmr_prescale_top_tb.sv
`timescale 1ns/1ps
module ltmr_prescale_top_tb;
  localparam logic [63:0] HALF = 64'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, alt_tick = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        cnt_tick, cnt_tick_n;
  logic [63:0] count;
  logic [7:0]  count_n;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // shadow model state
  logic        sh_alt = 0, sh_step2 = 0;
  logic [31:0] sh_rate = 0;
  logic [63:0] res = 0, exp_cnt = 0;

  always #2.5 clk = ~clk;

  ltmr_prescale_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .alt_tick_i(alt_tick),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cnt_tick_o(cnt_tick), .count_o(count)
  );

  ltmr_prescale_top #(.CNT_W(8)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .alt_tick_i(alt_tick),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cnt_tick_o(cnt_tick_n), .count_o(count_n)
  );

  // {mode, rate, ref ticks, alt ticks}
  localparam logic [79:0] VEC [0:7] = '{
    {32'h0000_0000, 32'h8000_0000, 8'd10, 8'd10},
    {32'h0000_0100, 32'h8000_0000, 8'd6,  8'd12},
    {32'h0000_0200, 32'h8000_0000, 8'd8,  8'd0 },
    {32'h0000_0000, 32'h4000_0000, 8'd20, 8'd5 },
    {32'h0000_0300, 32'h2AAA_AAAB, 8'd9,  8'd30},
    {32'h0000_0000, 32'h0000_0000, 8'd15, 8'd15},
    {32'h0000_0000, 32'hFFFF_FFFF, 8'd10, 8'd0 },
    {32'h0000_0200, 32'h9000_0000, 8'd12, 8'd0 }
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4";
      1: return "R2";
      2: return "R3";
      3, 4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; called and returns at a falling edge.
  task automatic step_tick(input logic r, input logic a, input logic w,
                           input logic s, input logic [31:0] d, input string tag);
    logic        src, exp_t;
    logic [63:0] peff, total;
    ref_tick = r; alt_tick = a; reg_wr = w; reg_sel = s; reg_wdata = d;
    src   = sh_alt ? a : r;
    peff  = ({32'b0, sh_rate} > HALF) ? HALF : {32'b0, sh_rate};
    exp_t = 1'b0;
    if (src) begin
      total = res + peff;
      exp_t = (total / HALF) != 0;
      res   = total % HALF;
      if (exp_t) exp_cnt = exp_cnt + (sh_step2 ? 64'd2 : 64'd1);
    end
    #1;
    check(cnt_tick == exp_t, "R10", {63'b0, cnt_tick}, {63'b0, exp_t});
    @(posedge clk);
    @(negedge clk);
    ref_tick = 0; alt_tick = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    if (w) begin
      if (!s) begin sh_alt = d[8]; sh_step2 = d[9]; end
      else sh_rate = d;
    end
    check(count == exp_cnt, tag, count, exp_cnt);
  endtask

  task automatic write_reg(input logic s, input logic [31:0] d);
    step_tick(1'b0, 1'b0, 1'b1, s, d, "R9");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(count == 0, "R1", count, 0);
    #1 check(cnt_tick == 0, "R1", {63'b0, cnt_tick}, 0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) step_tick(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R1");

    // Vector table
    for (int v = 0; v < 8; v++) begin
      logic [31:0] vm, vr;
      logic [7:0]  nr, na;
      logic [63:0] c0, r0, peff, nsel, exp_delta;
      int          nmax;
      {vm, vr, nr, na} = VEC[v];
      write_reg(1'b0, vm);
      write_reg(1'b1, vr);
      c0   = count;
      r0   = res;
      peff = ({32'b0, vr} > HALF) ? HALF : {32'b0, vr};
      nsel = vm[8] ? {56'b0, na} : {56'b0, nr};
      nmax = (nr > na) ? int'(nr) : int'(na);
      for (int i = 0; i < nmax; i++)
        step_tick(i < int'(nr), i < int'(na), 1'b0, 1'b0, 32'h0, vec_tag(v));
      exp_delta = ((r0 + nsel * peff) / HALF) * (vm[9] ? 64'd2 : 64'd1);
      check(count - c0 == exp_delta, vec_tag(v), count - c0, exp_delta);
    end

    // R9: writes coinciding with a selected tick
    write_reg(1'b0, 32'h0);
    write_reg(1'b1, 32'h8000_0000);
    step_tick(1'b1, 1'b0, 1'b1, 1'b1, 32'h0, "R9");          // old unity rate
    step_tick(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R9");          // now stopped
    step_tick(1'b1, 1'b0, 1'b1, 1'b1, 32'h8000_0000, "R9");  // old zero rate
    step_tick(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R9");
    step_tick(1'b1, 1'b0, 1'b1, 1'b0, 32'h200, "R9");        // old step 1
    step_tick(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R9");          // step 2
    step_tick(1'b0, 1'b1, 1'b1, 1'b0, 32'h100, "R9");        // old source: ref
    step_tick(1'b0, 1'b1, 1'b0, 1'b0, 32'h0, "R9");          // alt now counts

    // R8: run past the narrow width and compare
    write_reg(1'b0, 32'h200);
    for (int i = 0; i < 200; i++) step_tick(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R8");
    check(count > 64'd255, "R8", count, 64'd256);
    check(count_n == count[7:0], "R8", {56'b0, count_n}, {56'b0, count[7:0]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule